// File: doc/BRIEF.md
# Output Port Register Block with Atomic Bit Set and Clear

This block holds the output data of one general-purpose port and gives software three ways to change it over a simple synchronous register bus. Software can load the whole port at once through the data register. It can also change individual bits through a set register or a clear register, which avoids a read-modify-write sequence. The latched data drives the output vector. Reads of the set register return the synchronized state of the pins, not the latch. Reads of the clear register always return zero.

A parameter chooses how many low bits of the port exist, either 8 or 4. On a narrow instance the upper bits hold no state, and they read as zero from every register.

Top module: `gpio_setclr_port`

## Requirements
- R1: After synchronous active-low reset, `port_out` is 0 and `rd_data` is 0.
- R2: A write to the data register (byte offset 0x0) loads every implemented bit with the written value. A read of it returns the latched output data.
- R3: A write to the set register (offset 0x4) forces to 1 each implemented bit written as 1. Bits written as 0 keep their value.
- R4: A write to the clear register (offset 0x8) forces to 0 each implemented bit written as 0. Bits written as 1 keep their value.
- R5: A read of the clear register returns all zeros.
- R6: A read of the set register returns the pin-input vector after a two-flop synchronizer. That is the pin value sampled two clock edges before the read edge, masked to the implemented bits.
- R7: An access to any other offset reads as zero. A write to such an offset leaves `port_out` unchanged.
- R8: With IMPL_W = 4, bits 7:4 of `port_out` and of every read are 0. Writes to those bits have no effect in every register.
- R9: A write takes effect on its clock edge, so the new value is on `port_out` in the following cycle. `rd_data` is registered and updates in the cycle after a read; without a read it holds its value. A read that shares a cycle with a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Byte offset of the register accessed |
| we | input | 1 | Write enable |
| wdata | input | PORT_W | Write data |
| re | input | 1 | Read enable |
| rd_data | output | PORT_W | Registered read data |
| pins_in | input | PORT_W | Asynchronous pin states |
| port_out | output | PORT_W | Latched output data |

## Verification
A read and a write can share one cycle, because the bus carries both enables with a single address. The bench raises `we` and `re` together on the data register and on the set register. The data-register read must return the latch from before the write, and the set-register read must return the synchronized pins, while `port_out` takes the written result one cycle later. The pins also change from cycle to cycle during set-register reads, so the model's two-edge delay is tested against values in motion. Both an 8-bit and a 4-bit instance are compared against the model on every clock.

// File: rtl/gpio_setclr_pkg.sv
// Shared definitions for the port register block: register offsets and
// the decoded operation type. Assumes byte offsets on a 4-bit field.
package gpio_setclr_pkg;
    localparam logic [3:0] OFS_DATA = 4'h0;
    localparam logic [3:0] OFS_SET  = 4'h4;
    localparam logic [3:0] OFS_CLR  = 4'h8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_DATA = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } reg_op_e;
endpackage

// File: rtl/gpio_setclr_decode.sv
// Address decoder: maps a bus offset to the register it selects.
// Assumes ADDR_W >= 4; any offset not listed decodes to OP_NONE.
module gpio_setclr_decode
    import gpio_setclr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_op_e           op
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

    // Select the register named by the offset.
    always_comb begin
        if (addr == A_DATA)     op = OP_DATA;
        else if (addr == A_SET) op = OP_SET;
        else if (addr == A_CLR) op = OP_CLR;
        else                    op = OP_NONE;
    end
endmodule

// File: rtl/gpio_setclr_sync.sv
// Multi-flop synchronizer for the pin inputs. It assumes the pins are
// asynchronous to clk and that each bit can be synchronized on its own.
module gpio_setclr_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Later stages shift toward the output.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_setclr_latch.sv
// Output data latch with load, set-by-ones and clear-by-zeros updates.
// Assumes at most one of the three strobes is active per cycle; MASK marks
// the bits that hold state.
module gpio_setclr_latch #(
    parameter int              WIDTH = 8,
    parameter logic [WIDTH-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Apply the selected update to the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (ld_en)  q <= wdata & MASK;
        else if (set_en) q <= q | (wdata & MASK);
        else if (clr_en) q <= q & wdata & MASK;
    end

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> q == ($past(wdata) & MASK));
    // R3
    set_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !ld_en) |=> ((q & $past(wdata) & MASK) == ($past(wdata) & MASK))
                            && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
    // R4
    clear_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !ld_en && !set_en) |=> ((q & ~$past(wdata)) == '0)
                            && ((q & $past(wdata)) == ($past(q) & $past(wdata))));
    // R8
    upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~MASK) == '0);
endmodule

// File: rtl/gpio_setclr_port.sv
// Port register block: a data register, a set register and a clear
// register on a synchronous bus, with registered read data. It assumes
// IMPL_W <= PORT_W; bits at or above IMPL_W hold no state and read as zero.
module gpio_setclr_port
    import gpio_setclr_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int IMPL_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [PORT_W-1:0] wdata,
    input  logic              re,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pins_in,
    output logic [PORT_W-1:0] port_out
);
    localparam logic [PORT_W-1:0] MASK = PORT_W'((1 << IMPL_W) - 1);
    localparam int SYNC_STAGES = 2;

    reg_op_e           op;
    logic [PORT_W-1:0] pins_sync;
    logic [PORT_W-1:0] rd_next;

    gpio_setclr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .op   (op)
    );

    gpio_setclr_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_in),
        .q     (pins_sync)
    );

    gpio_setclr_latch #(.WIDTH(PORT_W), .MASK(MASK)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (we && op == OP_DATA),
        .set_en (we && op == OP_SET),
        .clr_en (we && op == OP_CLR),
        .wdata  (wdata),
        .q      (port_out)
    );

    // Choose the read value for the selected register.
    always_comb begin
        case (op)
            OP_DATA: rd_next = port_out;
            OP_SET:  rd_next = pins_sync & MASK;
            default: rd_next = '0;
        endcase
    end

    // Register the read data; it holds while no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_data <= '0;
        else if (re) rd_data <= rd_next;
    end

    // R5
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && op == OP_CLR) |=> rd_data == '0);
    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_NONE) |=> $stable(port_out));
    // R7
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && op == OP_NONE) |=> rd_data == '0);
    // R9
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && we && op == OP_DATA) |=> rd_data == $past(port_out));
    // R8
    read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~MASK) == '0);
endmodule

// File: tb/gpio_setclr_port_tb.sv
// Bench: drives one bus into a full-width and a 4-bit instance and compares
// both with a behavioural model on every clock.
module gpio_setclr_port_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   addr = '0;
    logic         we = 1'b0;
    logic         re = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] pins = '0;
    logic [W-1:0] rd8, out8, rd4, out4;

    int checks = 0;
    int fails = 0;
    string tag = "R1";
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_setclr_port #(.PORT_W(W), .IMPL_W(8), .ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .re(re), .rd_data(rd8), .pins_in(pins), .port_out(out8));

    gpio_setclr_port #(.PORT_W(W), .IMPL_W(4), .ADDR_W(4)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .re(re), .rd_data(rd4), .pins_in(pins), .port_out(out4));

    // Reference model state: [0] full instance, [1] narrow instance.
    int m_out [2];
    int m_rd  [2];
    int p1, p2;
    int msk [2] = '{255, 15};

    always @(posedge clk) begin
        int nout [2];
        int nrd  [2];
        for (int i = 0; i < 2; i++) begin
            nout[i] = m_out[i];
            nrd[i]  = m_rd[i];
            if (re) begin
                if (addr == 4'h0)      nrd[i] = m_out[i];
                else if (addr == 4'h4) nrd[i] = p2 & msk[i];
                else                   nrd[i] = 0;
            end
            if (we) begin
                if (addr == 4'h0)      nout[i] = int'(wdata) & msk[i];
                else if (addr == 4'h4) nout[i] = m_out[i] | (int'(wdata) & msk[i]);
                else if (addr == 4'h8) nout[i] = m_out[i] & int'(wdata);
            end
            if (!rst_n) begin
                nout[i] = 0;
                nrd[i]  = 0;
            end
        end
        if (!rst_n) begin
            p2 <= 0; p1 <= 0;
        end else begin
            p2 <= p1; p1 <= int'(pins);
        end
        m_out <= nout;
        m_rd  <= nrd;
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // Compare both instances mid-cycle, away from the edge.
    always @(negedge clk) begin
        if (!done) begin
            cmp("port_out[8b]", int'(out8), m_out[0]);
            cmp("rd_data[8b]",  int'(rd8),  m_rd[0]);
            cmp("port_out[4b]", int'(out4), m_out[1]);
            cmp("rd_data[4b]",  int'(rd4),  m_rd[1]);
        end
    end

    task automatic bus(string t, bit w, bit r, logic [3:0] a, logic [W-1:0] d);
        @(posedge clk);
        #1;
        tag = t; we = w; re = r; addr = a; wdata = d;
    endtask

    task automatic idle(string t);
        bus(t, 1'b0, 1'b0, 4'h0, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle("R1");
        bus("R2", 1, 0, 4'h0, 8'hA5);          // load
        bus("R2", 0, 1, 4'h0, 8'h00);          // read latch
        bus("R3", 1, 0, 4'h4, 8'h5A);          // set ones
        bus("R2", 0, 1, 4'h0, 8'h00);
        bus("R3", 1, 0, 4'h4, 8'h00);          // set with zeros: no change
        bus("R4", 1, 0, 4'h8, 8'hF0);          // clear low nibble
        bus("R4", 1, 0, 4'h8, 8'hFF);          // all ones: no change
        bus("R4", 1, 0, 4'h8, 8'h7F);          // clear bit 7
        bus("R2", 0, 1, 4'h0, 8'h00);
        bus("R5", 0, 1, 4'h8, 8'h00);          // clear reads zero
        pins = 8'hC3;
        idle("R6"); idle("R6");
        bus("R6", 0, 1, 4'h4, 8'h00);          // pins read
        for (int k = 0; k < 6; k++) begin      // pins moving during reads
            pins = pins * 8'd5 + 8'd3;
            bus("R6", 0, 1, 4'h4, 8'h00);
        end
        bus("R2", 1, 0, 4'h0, 8'h3C);
        bus("R7", 1, 0, 4'hC, 8'hFF);          // unmapped write
        bus("R7", 1, 0, 4'h2, 8'h00);
        bus("R7", 0, 1, 4'hC, 8'h00);          // unmapped read
        bus("R7", 0, 1, 4'h1, 8'h00);
        bus("R9", 1, 1, 4'h0, 8'h96);          // read and write together
        bus("R9", 1, 1, 4'h0, 8'h0F);
        bus("R9", 1, 1, 4'h4, 8'hF0);          // set write with pin read
        bus("R9", 1, 1, 4'h8, 8'h00);          // clear write with zero read
        bus("R9", 0, 1, 4'h0, 8'h00);
        idle("R9");
        bus("R8", 1, 0, 4'h0, 8'hFF);          // narrow instance keeps 0x0F
        bus("R8", 0, 1, 4'h0, 8'h00);
        bus("R8", 1, 0, 4'h8, 8'h0F);          // upper zeros no effect on narrow
        pins = 8'hFF;
        bus("R8", 1, 0, 4'h4, 8'hF0);
        idle("R8");
        bus("R8", 0, 1, 4'h4, 8'h00);
        bus("R1", 0, 0, 4'h0, 8'h00);
        #1 rst_n = 1'b0;                       // reset mid-run
        @(posedge clk); #1 rst_n = 1'b1;
        idle("R1"); idle("R1");
        @(posedge clk); #5;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule